// File: doc/BRIEF.md
# Cache-Side Coherence Line Controller

This block holds the coherence state of a handful of cache lines at one processing site of a directory-based coherence scheme. The processor side issues loads and stores. The home directory sends requests and replies over an inbound queue. The block reads both, updates each line's state and data, and emits at most one message per cycle toward home. It also reports whether a processor access completed (hit) or must wait (stall), and whether a reply filled a line. Message kinds travel as a 4-bit type code. An outbound message carries the site's own id as source, the home id as destination, the line address and, for replies that return data, the line contents.

Every line sits in one of four states: LN_NOTHING (no copy), LN_SHARED (clean copy), LN_EXCL (modified, only copy) and LN_PEND (request issued, reply outstanding). The named transitions are: miss-load (NOTHING to PEND), miss-store (NOTHING to PEND), shared fill (NOTHING or PEND to SHARED), exclusive fill (NOTHING or PEND to EXCL), upgrade (SHARED to EXCL, no data), invalidate (SHARED to NOTHING), writeback (EXCL to SHARED), flush (EXCL to NOTHING), plus the three site-initiated actions drop (SHARED to NOTHING), downgrade (EXCL to SHARED) and self-flush (EXCL to NOTHING). A store to a SHARED line sets a per-line upgrade-outstanding flag so that the request toward home goes out once.

Each cycle serves one source, in priority order: inbound message, site-initiated action, processor access. The outbound port has a ready input. When a needed send cannot go out, an inbound message stays in the queue (in_deq low), and a site-initiated action or a processor miss does nothing that cycle. All outputs are combinational from the present state and inputs. State changes at the clock edge.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is LN_NOTHING and its upgrade flag is clear. With idle inputs, out_valid, cpu_hit, in_deq and fill_evt are all 0.
- R2: A load to a LN_NOTHING line with out_ready high sends type 0 (shared request) with out_src = SITE_ID, out_dst = HOME_ID and out_addr = line. It stalls and moves the line to LN_PEND. With out_ready low it sends nothing and the line stays LN_NOTHING.
- R3: A store to a LN_NOTHING line sends type 1 (exclusive request), stalls without writing data, and moves the line to LN_PEND.
- R4: A processor access to a LN_PEND line stalls and sends nothing. Inbound types 2 (writeback request), 3 (invalidate request) and 4 (flush request) aimed at a LN_NOTHING or LN_PEND line are dequeued with no message and no state change.
- R5: A load to LN_SHARED hits and returns the line data. In LN_SHARED, type 2 is dequeued with no effect. Type 3 or type 4 sends type 6 (invalidate reply, no data) and moves the line to LN_NOTHING.
- R6: In LN_EXCL, type 2 sends type 5 (writeback reply) carrying the line data and moves the line to LN_SHARED. Type 4 sends type 7 (flush reply) carrying the data and moves the line to LN_NOTHING. out_has_data is 1 exactly for types 5 and 7.
- R7: Type 8 (shared reply) to a LN_NOTHING or LN_PEND line writes in_data into the line, moves it to LN_SHARED and raises fill_evt. Type 9 (exclusive reply) in those states does the same but moves the line to LN_EXCL.
- R8: Type 9 arriving at a LN_SHARED line moves it to LN_EXCL, leaves the line data unchanged and does not raise fill_evt.
- R9: A store to a LN_SHARED line sends one type 1, keeps the line LN_SHARED and stalls. Further stores to that line send nothing until a type 9 arrives for it. This holds even if the line is invalidated meanwhile. The later type 9 then fills it as LN_EXCL.
- R10: A load or store to a LN_EXCL line hits in the same cycle. A store writes cpu_wdata into the line at the clock edge, and later loads return it.
- R11: Site-initiated actions, encoded by vol_kind: 0 drop (LN_SHARED to LN_NOTHING, sends type 6), 1 downgrade (LN_EXCL to LN_SHARED, sends type 5 with data), 2 self-flush (LN_EXCL to LN_NOTHING, sends type 7 with data). An action requested in any other state sends nothing and changes nothing.
- R12: When an inbound message needs a reply and out_ready is low, in_deq stays 0, nothing is sent and the line is unchanged. The same message is handled once out_ready rises.
- R13: A valid inbound message blocks site actions and processor accesses that cycle. A site action request blocks processor accesses. A blocked processor access stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor access present |
| cpu_store | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Line index of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_hit | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Access present but not completed |
| cpu_rdata | output | DATA_W | Current data of the addressed line |
| vol_valid | input | 1 | Site-initiated action request |
| vol_kind | input | 2 | 0 drop, 1 downgrade, 2 self-flush |
| vol_addr | input | AW | Line index of the action |
| in_valid | input | 1 | Inbound queue head is valid |
| in_type | input | 4 | Inbound message type code |
| in_addr | input | AW | Inbound message line index |
| in_data | input | DATA_W | Inbound reply data |
| in_deq | output | 1 | Queue head consumed this cycle |
| out_ready | input | 1 | Network can accept a message |
| out_valid | output | 1 | Outbound message present |
| out_type | output | 4 | Outbound message type code |
| out_src | output | ID_W | Sending site id |
| out_dst | output | ID_W | Home site id |
| out_addr | output | AW | Outbound line index |
| out_data | output | DATA_W | Line data for data-carrying replies, else 0 |
| out_has_data | output | 1 | Outbound message carries data |
| fill_evt | output | 1 | A reply wrote line data this cycle |

## Verification
The bench goes after a store to a shared line. A design that re-sent the exclusive request every stalled cycle would flood home with duplicates. One that wrote the reply data over the line on upgrade would lose the value already held. It checks the upgrade flag across an intervening invalidate: a design that cleared it would send a second request for a line whose exclusive reply is already on its way. It also holds a reply-needing message against a low out_ready, where a design that dequeued anyway would lose the reply, and it sends site actions to lines in the wrong state, where a design that acted anyway would emit spurious data or drop a modified copy.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LN_NOTHING = 2'd0,
        LN_SHARED  = 2'd1,
        LN_EXCL    = 2'd2,
        LN_PEND    = 2'd3
    } line_st_e;

    typedef enum logic [3:0] {
        MSG_SH_REQ    = 4'd0,
        MSG_EX_REQ    = 4'd1,
        MSG_WB_REQ    = 4'd2,
        MSG_INV_REQ   = 4'd3,
        MSG_FLUSH_REQ = 4'd4,
        MSG_WB_REP    = 4'd5,
        MSG_INV_REP   = 4'd6,
        MSG_FLUSH_REP = 4'd7,
        MSG_SH_REP    = 4'd8,
        MSG_EX_REP    = 4'd9
    } msg_e;

    typedef enum logic [1:0] {
        VOL_DROP  = 2'd0,
        VOL_DOWN  = 2'd1,
        VOL_FLUSH = 2'd2,
        VOL_RSVD  = 2'd3
    } vol_e;

endpackage

// File: rtl/coh_state_array.sv
module coh_state_array
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int AW        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ln_idx,
    input  logic            st_we,
    input  line_st_e        st_nxt,
    input  logic            upg_we,
    input  logic            upg_nxt,
    output line_st_e        st_q  [NUM_LINES],
    output logic            upg_q [NUM_LINES]
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[g]  <= LN_NOTHING;
                upg_q[g] <= 1'b0;
            end else if (ln_idx == AW'(g)) begin
                if (st_we)  st_q[g]  <= st_nxt;
                if (upg_we) upg_q[g] <= upg_nxt;
            end
        end
    end

endmodule

// File: rtl/coh_data_array.sv
module coh_data_array #(
    parameter int NUM_LINES = 4,
    parameter int AW        = 2,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd [NUM_LINES]
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     rd[g] <= '0;
            else if (we && idx == AW'(g))   rd[g] <= wdata;
        end
    end

endmodule

// File: rtl/coh_msg_engine.sv
module coh_msg_engine
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int AW        = 2,
    parameter int DATA_W    = 32
) (
    input  line_st_e          st_q      [NUM_LINES],
    input  logic              upg_q     [NUM_LINES],
    input  logic [DATA_W-1:0] line_data [NUM_LINES],
    input  logic              cpu_valid,
    input  logic              cpu_store,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              vol_valid,
    input  logic [1:0]        vol_kind,
    input  logic [AW-1:0]     vol_addr,
    input  logic              in_valid,
    input  logic [3:0]        in_type,
    input  logic [AW-1:0]     in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              out_ready,
    output logic [AW-1:0]     ln_idx,
    output logic              st_we,
    output line_st_e          st_nxt,
    output logic              upg_we,
    output logic              upg_nxt,
    output logic              dat_we,
    output logic [DATA_W-1:0] dat_wdata,
    output logic              msg_valid,
    output msg_e              msg_type,
    output logic [AW-1:0]     msg_addr,
    output logic [DATA_W-1:0] msg_data,
    output logic              msg_has_data,
    output logic              deq,
    output logic              hit,
    output logic              fill
);

    msg_e     in_kind;
    vol_e     v_kind;
    line_st_e i_st, v_st, c_st;
    logic     c_upg;

    assign in_kind = msg_e'(in_type);
    assign v_kind  = vol_e'(vol_kind);
    assign i_st    = st_q[in_addr];
    assign v_st    = st_q[vol_addr];
    assign c_st    = st_q[cpu_addr];
    assign c_upg   = upg_q[cpu_addr];

    always_comb begin
        ln_idx       = '0;
        st_we        = 1'b0;
        st_nxt       = LN_NOTHING;
        upg_we       = 1'b0;
        upg_nxt      = 1'b0;
        dat_we       = 1'b0;
        dat_wdata    = '0;
        msg_valid    = 1'b0;
        msg_type     = MSG_SH_REQ;
        msg_addr     = '0;
        msg_data     = '0;
        msg_has_data = 1'b0;
        deq          = 1'b0;
        hit          = 1'b0;
        fill         = 1'b0;

        if (in_valid) begin
            ln_idx   = in_addr;
            msg_addr = in_addr;
            unique case (in_kind)
                MSG_WB_REQ: begin
                    if (i_st == LN_EXCL) begin
                        if (out_ready) begin
                            deq          = 1'b1;
                            msg_valid    = 1'b1;
                            msg_type     = MSG_WB_REP;
                            msg_data     = line_data[in_addr];
                            msg_has_data = 1'b1;
                            st_we        = 1'b1;
                            st_nxt       = LN_SHARED;
                        end
                    end else begin
                        deq = 1'b1;
                    end
                end
                MSG_FLUSH_REQ: begin
                    if (i_st == LN_EXCL) begin
                        if (out_ready) begin
                            deq          = 1'b1;
                            msg_valid    = 1'b1;
                            msg_type     = MSG_FLUSH_REP;
                            msg_data     = line_data[in_addr];
                            msg_has_data = 1'b1;
                            st_we        = 1'b1;
                            st_nxt       = LN_NOTHING;
                        end
                    end else if (i_st == LN_SHARED) begin
                        if (out_ready) begin
                            deq       = 1'b1;
                            msg_valid = 1'b1;
                            msg_type  = MSG_INV_REP;
                            st_we     = 1'b1;
                            st_nxt    = LN_NOTHING;
                        end
                    end else begin
                        deq = 1'b1;
                    end
                end
                MSG_INV_REQ: begin
                    if (i_st == LN_SHARED) begin
                        if (out_ready) begin
                            deq       = 1'b1;
                            msg_valid = 1'b1;
                            msg_type  = MSG_INV_REP;
                            st_we     = 1'b1;
                            st_nxt    = LN_NOTHING;
                        end
                    end else begin
                        deq = 1'b1;
                    end
                end
                MSG_SH_REP: begin
                    deq = 1'b1;
                    if (i_st == LN_NOTHING || i_st == LN_PEND) begin
                        fill      = 1'b1;
                        dat_we    = 1'b1;
                        dat_wdata = in_data;
                        st_we     = 1'b1;
                        st_nxt    = LN_SHARED;
                    end
                end
                MSG_EX_REP: begin
                    deq = 1'b1;
                    if (i_st == LN_NOTHING || i_st == LN_PEND) begin
                        fill      = 1'b1;
                        dat_we    = 1'b1;
                        dat_wdata = in_data;
                        st_we     = 1'b1;
                        st_nxt    = LN_EXCL;
                        upg_we    = 1'b1;
                        upg_nxt   = 1'b0;
                    end else if (i_st == LN_SHARED) begin
                        st_we     = 1'b1;
                        st_nxt    = LN_EXCL;
                        upg_we    = 1'b1;
                        upg_nxt   = 1'b0;
                    end
                end
                default: deq = 1'b1;
            endcase
        end else if (vol_valid) begin
            ln_idx   = vol_addr;
            msg_addr = vol_addr;
            unique case (v_kind)
                VOL_DROP: begin
                    if (v_st == LN_SHARED && out_ready) begin
                        msg_valid = 1'b1;
                        msg_type  = MSG_INV_REP;
                        st_we     = 1'b1;
                        st_nxt    = LN_NOTHING;
                    end
                end
                VOL_DOWN: begin
                    if (v_st == LN_EXCL && out_ready) begin
                        msg_valid    = 1'b1;
                        msg_type     = MSG_WB_REP;
                        msg_data     = line_data[vol_addr];
                        msg_has_data = 1'b1;
                        st_we        = 1'b1;
                        st_nxt       = LN_SHARED;
                    end
                end
                VOL_FLUSH: begin
                    if (v_st == LN_EXCL && out_ready) begin
                        msg_valid    = 1'b1;
                        msg_type     = MSG_FLUSH_REP;
                        msg_data     = line_data[vol_addr];
                        msg_has_data = 1'b1;
                        st_we        = 1'b1;
                        st_nxt       = LN_NOTHING;
                    end
                end
                default: ;
            endcase
        end else if (cpu_valid) begin
            ln_idx   = cpu_addr;
            msg_addr = cpu_addr;
            unique case (c_st)
                LN_NOTHING: begin
                    if (!c_upg && out_ready) begin
                        msg_valid = 1'b1;
                        msg_type  = cpu_store ? MSG_EX_REQ : MSG_SH_REQ;
                        st_we     = 1'b1;
                        st_nxt    = LN_PEND;
                    end
                end
                LN_SHARED: begin
                    if (!cpu_store) begin
                        hit = 1'b1;
                    end else if (!c_upg && out_ready) begin
                        msg_valid = 1'b1;
                        msg_type  = MSG_EX_REQ;
                        upg_we    = 1'b1;
                        upg_nxt   = 1'b1;
                    end
                end
                LN_EXCL: begin
                    hit = 1'b1;
                    if (cpu_store) begin
                        dat_we    = 1'b1;
                        dat_wdata = cpu_wdata;
                    end
                end
                LN_PEND: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int SITE_ID   = 1,
    parameter int HOME_ID   = 0,
    localparam int AW       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_store,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_hit,
    output logic              cpu_stall,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              vol_valid,
    input  logic [1:0]        vol_kind,
    input  logic [AW-1:0]     vol_addr,
    input  logic              in_valid,
    input  logic [3:0]        in_type,
    input  logic [AW-1:0]     in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_deq,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [3:0]        out_type,
    output logic [ID_W-1:0]   out_src,
    output logic [ID_W-1:0]   out_dst,
    output logic [AW-1:0]     out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic              out_has_data,
    output logic              fill_evt
);

    line_st_e          st_q      [NUM_LINES];
    logic              upg_q     [NUM_LINES];
    logic [DATA_W-1:0] line_data [NUM_LINES];

    logic [AW-1:0]     ln_idx;
    logic              st_we, upg_we, upg_nxt, dat_we;
    line_st_e          st_nxt;
    logic [DATA_W-1:0] dat_wdata;
    msg_e              msg_type;

    coh_state_array #(.NUM_LINES(NUM_LINES), .AW(AW)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .ln_idx  (ln_idx),
        .st_we   (st_we),
        .st_nxt  (st_nxt),
        .upg_we  (upg_we),
        .upg_nxt (upg_nxt),
        .st_q    (st_q),
        .upg_q   (upg_q)
    );

    coh_data_array #(.NUM_LINES(NUM_LINES), .AW(AW), .DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dat_we),
        .idx   (ln_idx),
        .wdata (dat_wdata),
        .rd    (line_data)
    );

    coh_msg_engine #(.NUM_LINES(NUM_LINES), .AW(AW), .DATA_W(DATA_W)) u_engine (
        .st_q         (st_q),
        .upg_q        (upg_q),
        .line_data    (line_data),
        .cpu_valid    (cpu_valid),
        .cpu_store    (cpu_store),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .vol_valid    (vol_valid),
        .vol_kind     (vol_kind),
        .vol_addr     (vol_addr),
        .in_valid     (in_valid),
        .in_type      (in_type),
        .in_addr      (in_addr),
        .in_data      (in_data),
        .out_ready    (out_ready),
        .ln_idx       (ln_idx),
        .st_we        (st_we),
        .st_nxt       (st_nxt),
        .upg_we       (upg_we),
        .upg_nxt      (upg_nxt),
        .dat_we       (dat_we),
        .dat_wdata    (dat_wdata),
        .msg_valid    (out_valid),
        .msg_type     (msg_type),
        .msg_addr     (out_addr),
        .msg_data     (out_data),
        .msg_has_data (out_has_data),
        .deq          (in_deq),
        .hit          (cpu_hit),
        .fill         (fill_evt)
    );

    assign out_type  = msg_type;
    assign out_src   = ID_W'(SITE_ID);
    assign out_dst   = ID_W'(HOME_ID);
    assign cpu_rdata = line_data[cpu_addr];
    assign cpu_stall = cpu_valid && !cpu_hit;

    // R2: a shared request leaves its line waiting for the reply
    p_miss_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_type == 4'd0 |=> st_q[$past(out_addr)] == LN_PEND);

    // R6: a writeback reply leaves a clean shared copy behind
    p_wbrep_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_type == 4'd5 |=> st_q[$past(out_addr)] == LN_SHARED);

    // R7: a fill only happens while a message is consumed
    p_fill_consumes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_evt |-> in_valid && in_deq);

    // R9: no back-to-back exclusive request for a line that stays shared
    p_upg_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_type == 4'd1 && st_q[out_addr] == LN_SHARED
        |=> !(out_valid && out_type == 4'd1 && out_addr == $past(out_addr)));

    // R10: a store hit lands in the line array
    p_store_hit_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit && cpu_store |=> line_data[$past(cpu_addr)] == $past(cpu_wdata));

    // R12: a held message produces neither reply nor fill
    p_held_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_deq |-> !out_valid && !fill_evt);

    // R13: an inbound message keeps the processor waiting
    p_inbound_blocks_r13: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !cpu_hit);

endmodule

// File: tb/tb_coh_line_ctrl.sv
module tb_coh_line_ctrl;

    localparam int DW = 32;

    typedef struct packed {
        logic [3:0]  req;
        logic        cv;
        logic        cs;
        logic [1:0]  ca;
        logic [31:0] cw;
        logic        vv;
        logic [1:0]  vk;
        logic [1:0]  va;
        logic        iv;
        logic [3:0]  it;
        logic [1:0]  ia;
        logic [31:0] id;
        logic        rdy;
        logic        e_hit;
        logic        e_deq;
        logic        e_ov;
        logic [3:0]  e_ot;
        logic [1:0]  e_oa;
        logic [31:0] e_od;
        logic        e_fill;
        logic [31:0] e_rd;
    } vec_t;

    // fields: req | cv cs ca cw | vv vk va | iv it ia id | rdy | hit deq ov ot oa od fill rd
    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{2,  1,0,0,0,        0,0,0, 0,0,0,0,        1, 0,0,1,0,0,0,        0,0},        // R2 load miss a0
        '{4,  1,0,0,0,        0,0,0, 0,0,0,0,        1, 0,0,0,0,0,0,        0,0},        // R4 pending stalls
        '{4,  1,0,0,0,        0,0,0, 1,2,0,0,        1, 0,1,0,0,0,0,        0,0},        // R4 wb req in pending
        '{7,  1,0,0,0,        0,0,0, 1,8,0,32'h1111, 1, 0,1,0,0,0,0,        1,0},        // R7 shared fill a0
        '{5,  1,0,0,0,        0,0,0, 0,0,0,0,        1, 1,0,0,0,0,0,        0,32'h1111}, // R5 load hit shared
        '{5,  0,0,0,0,        0,0,0, 1,2,0,0,        1, 0,1,0,0,0,0,        0,0},        // R5 wb req in shared
        '{5,  1,0,0,0,        0,0,0, 0,0,0,0,        1, 1,0,0,0,0,0,        0,32'h1111}, // R5 still shared
        '{3,  1,1,1,32'h2222, 0,0,0, 0,0,0,0,        1, 0,0,1,1,1,0,        0,0},        // R3 store miss a1
        '{7,  0,0,0,0,        0,0,0, 1,9,1,32'h3333, 1, 0,1,0,0,0,0,        1,0},        // R7 excl fill a1
        '{10, 1,1,1,32'h2222, 0,0,0, 0,0,0,0,        1, 1,0,0,0,0,0,        0,32'h3333}, // R10 store hit
        '{10, 1,0,1,0,        0,0,0, 0,0,0,0,        1, 1,0,0,0,0,0,        0,32'h2222}, // R10 load sees store
        '{12, 0,0,0,0,        0,0,0, 1,2,1,0,        0, 0,0,0,0,0,0,        0,0},        // R12 held
        '{6,  0,0,0,0,        0,0,0, 1,2,1,0,        1, 0,1,1,5,1,32'h2222, 0,0},        // R6 wb reply
        '{9,  1,1,1,32'h4444, 0,0,0, 0,0,0,0,        1, 0,0,1,1,1,0,        0,0},        // R9 upgrade request
        '{9,  1,1,1,32'h4444, 0,0,0, 0,0,0,0,        1, 0,0,0,0,0,0,        0,0},        // R9 no duplicate
        '{8,  0,0,0,0,        0,0,0, 1,9,1,32'h5555, 1, 0,1,0,0,0,0,        0,0},        // R8 upgrade grant
        '{8,  1,1,1,32'h4444, 0,0,0, 0,0,0,0,        1, 1,0,0,0,0,0,        0,32'h2222}, // R8 data kept
        '{6,  0,0,0,0,        0,0,0, 1,4,1,0,        1, 0,1,1,7,1,32'h4444, 0,0},        // R6 flush reply
        '{4,  0,0,0,0,        0,0,0, 1,3,1,0,        1, 0,1,0,0,0,0,        0,0},        // R4 inv in nothing
        '{2,  1,0,1,0,        0,0,0, 0,0,0,0,        1, 0,0,1,0,1,0,        0,0},        // R2 miss a1
        '{5,  0,0,0,0,        0,0,0, 1,4,0,0,        1, 0,1,1,6,0,0,        0,0},        // R5 flush in shared
        '{11, 0,0,0,0,        1,0,2, 0,0,0,0,        1, 0,0,0,0,0,0,        0,0},        // R11 drop ignored
        '{7,  0,0,0,0,        0,0,0, 1,8,2,32'h6666, 1, 0,1,0,0,0,0,        1,0},        // R7 prefetch fill
        '{11, 0,0,0,0,        1,0,2, 0,0,0,0,        1, 0,0,1,6,2,0,        0,0},        // R11 drop
        '{7,  0,0,0,0,        0,0,0, 1,9,3,32'h7777, 1, 0,1,0,0,0,0,        1,0},        // R7 excl fill a3
        '{13, 1,0,3,0,        1,1,3, 0,0,0,0,        1, 0,0,1,5,3,32'h7777, 0,0},        // R13 downgrade wins
        '{11, 1,0,3,0,        1,2,3, 0,0,0,0,        1, 0,0,0,0,0,0,        0,0},        // R11 flush ignored
        '{5,  1,0,3,0,        0,0,0, 0,0,0,0,        1, 1,0,0,0,0,0,        0,32'h7777}, // R5 load hit a3
        '{5,  0,0,0,0,        0,0,0, 1,3,3,0,        1, 0,1,1,6,3,0,        0,0},        // R5 invalidate
        '{2,  1,0,3,0,        0,0,0, 0,0,0,0,        0, 0,0,0,0,0,0,        0,0},        // R2 not ready
        '{2,  1,0,3,0,        0,0,0, 0,0,0,0,        1, 0,0,1,0,3,0,        0,0}         // R2 miss a3
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 0, cpu_store = 0;
    logic [1:0]    cpu_addr = 0;
    logic [DW-1:0] cpu_wdata = 0;
    logic          cpu_hit, cpu_stall;
    logic [DW-1:0] cpu_rdata;
    logic          vol_valid = 0;
    logic [1:0]    vol_kind = 0, vol_addr = 0;
    logic          in_valid = 0;
    logic [3:0]    in_type = 0;
    logic [1:0]    in_addr = 0;
    logic [DW-1:0] in_data = 0;
    logic          in_deq, out_ready = 0, out_valid;
    logic [3:0]    out_type, out_src, out_dst;
    logic [1:0]    out_addr;
    logic [DW-1:0] out_data;
    logic          out_has_data, fill_evt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    coh_line_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_store(cpu_store), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
        .cpu_rdata(cpu_rdata),
        .vol_valid(vol_valid), .vol_kind(vol_kind), .vol_addr(vol_addr),
        .in_valid(in_valid), .in_type(in_type), .in_addr(in_addr),
        .in_data(in_data), .in_deq(in_deq),
        .out_ready(out_ready), .out_valid(out_valid), .out_type(out_type),
        .out_src(out_src), .out_dst(out_dst), .out_addr(out_addr),
        .out_data(out_data), .out_has_data(out_has_data), .fill_evt(fill_evt)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic ok;
        logic e_hd;
        @(negedge clk);
        cpu_valid = v.cv; cpu_store = v.cs; cpu_addr = v.ca; cpu_wdata = v.cw;
        vol_valid = v.vv; vol_kind = v.vk; vol_addr = v.va;
        in_valid = v.iv; in_type = v.it; in_addr = v.ia; in_data = v.id;
        out_ready = v.rdy;
        #1;
        e_hd = v.e_ov && (v.e_ot == 4'd5 || v.e_ot == 4'd7);
        ok = (cpu_hit == v.e_hit) && (cpu_stall == (v.cv && !v.e_hit))
          && (in_deq == v.e_deq) && (out_valid == v.e_ov) && (fill_evt == v.e_fill);
        if (v.e_ov)
            ok = ok && out_type == v.e_ot && out_addr == v.e_oa
                    && out_has_data == e_hd && out_src == 4'd1 && out_dst == 4'd0
                    && (!e_hd || out_data == v.e_od);
        if (v.e_hit)
            ok = ok && cpu_rdata == v.e_rd;
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d step %0d: got hit=%b stall=%b deq=%b ov=%b ot=%0d oa=%0d od=%h hd=%b fill=%b rd=%h src=%0d dst=%0d; want hit=%b deq=%b ov=%b ot=%0d oa=%0d od=%h hd=%b fill=%b rd=%h src=1 dst=0",
                v.req, idx, cpu_hit, cpu_stall, in_deq, out_valid, out_type, out_addr,
                out_data, out_has_data, fill_evt, cpu_rdata, out_src, out_dst,
                v.e_hit, v.e_deq, v.e_ov, v.e_ot, v.e_oa, v.e_od, e_hd, v.e_fill, v.e_rd);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        cpu_valid = 0; vol_valid = 0; in_valid = 0; out_ready = 0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout, want completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        go_idle();
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R1: reset again with idle inputs, outputs must be quiet
        go_idle();
        rst_n = 1'b0;
        #1;
        checks++;
        if (out_valid || cpu_hit || in_deq || fill_evt) begin
            errors++;
            $display("FAIL R1 reset outputs: got ov=%b hit=%b deq=%b fill=%b, want 0 0 0 0",
                out_valid, cpu_hit, in_deq, fill_evt);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1: lines a1 and a3 were pending before reset, now they miss again
        run_vec('{1, 1,0,1,0, 0,0,0, 0,0,0,0, 1, 0,0,1,0,1,0, 0,0}, 100);
        run_vec('{1, 1,1,3,0, 0,0,0, 0,0,0,0, 1, 0,0,1,1,3,0, 0,0}, 101);

        // R9: upgrade flag survives an invalidate on line a2
        run_vec('{7, 0,0,0,0, 0,0,0, 1,8,2,32'hA, 1, 0,1,0,0,0,0, 1,0}, 102);
        run_vec('{9, 1,1,2,32'hB, 0,0,0, 0,0,0,0, 1, 0,0,1,1,2,0, 0,0}, 103);
        run_vec('{9, 0,0,0,0, 0,0,0, 1,3,2,0, 1, 0,1,1,6,2,0, 0,0}, 104);
        run_vec('{9, 1,1,2,32'hB, 0,0,0, 0,0,0,0, 1, 0,0,0,0,0,0, 0,0}, 105);
        run_vec('{9, 0,0,0,0, 0,0,0, 1,9,2,32'hC, 1, 0,1,0,0,0,0, 1,0}, 106);
        run_vec('{10, 1,1,2,32'hB, 0,0,0, 0,0,0,0, 1, 1,0,0,0,0,0, 0,32'hC}, 107);
        // R11: self-flush of an exclusive line, then downgrade of an empty line
        run_vec('{11, 0,0,0,0, 1,2,2, 0,0,0,0, 1, 0,0,1,7,2,32'hB, 0,0}, 108);
        run_vec('{11, 0,0,0,0, 1,1,2, 0,0,0,0, 1, 0,0,0,0,0,0, 0,0}, 109);
        // R4: unknown type code consumed without effect while a2 is empty
        run_vec('{4, 0,0,0,0, 0,0,0, 1,4'd12,2,0, 1, 0,1,0,0,0,0, 0,0}, 110);
        run_vec('{4, 1,0,2,0, 0,0,0, 0,0,0,0, 1, 0,0,1,0,2,0, 0,0}, 111);

        go_idle();
        finish_run();
    end

endmodule